// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block gathers the four interrupt causes of a UART (receiver line errors, a received character waiting, the transmit holding register going empty, and a change on the modem inputs) into one active-high interrupt line. It also produces an identification byte that names the most urgent cause that is both pending and enabled. The receiver, transmitter and modem-input logic supply one-cycle event pulses or status levels. The register-access logic of the UART supplies the strobes for the accesses that retire each cause.

Each cause keeps its own pending flag. A four-bit enable register masks the flags before they reach the interrupt line and the priority encoder. The transmit-empty cause is special. It is armed when the holding register drains, or when its enable bit is turned on while the register is already empty. It is retired either by a new transmit write or by software reading the identification byte while transmit-empty is the cause that byte names. The identification byte is frozen for the whole of a read access, so the value software receives cannot change under it.

Top module: `uirq_ident`

## Requirements
- R1: The enable register resets to 0. A write stores its four bits: bit 0 enables received-data, bit 1 transmit-empty, bit 2 line-status and bit 3 modem-status. The 8-bit readback carries those four bits in bits 3:0 and zero in bits 7:4.
- R2: The identification byte resets to 0x01. With nothing enabled and pending it reads 0x01. Otherwise bit 0 is 0, bits 3:1 hold the cause code (line-status 011, received-data 010, transmit-empty 001, modem-status 000), and bits 7:4 are 0. The byte follows a change in the pending set one cycle after the interrupt line does.
- R3: The interrupt output is 0 after reset. It is 1 exactly when at least one cause is both pending and enabled, and it is valid in the cycle after the event that sets or clears a flag.
- R4: When several enabled causes are pending, the identification byte names the highest-priority one, in the order line-status, received-data, transmit-empty, modem-status. A pending cause whose enable bit is 0 is never reported.
- R5: The line-status flag is set by a line-error event and cleared by a line-status read. The received-data flag is set by a character-loaded event and cleared by a receive-holding read. The modem flag is set by a modem-change event and cleared by a modem-status read. If a set and a clear arrive in the same cycle, the flag is set.
- R6: The transmit-empty flag is set when the holding-register-empty level rises, and is cleared by a transmit holding write. It is not set again while the empty level merely stays high.
- R7: The first cycle of an identification read clears the transmit-empty flag only if the byte being returned names transmit-empty. An identification read never clears the line-status, received-data or modem flags.
- R8: When the transmit-empty enable bit changes from 0 to 1 while the holding-register-empty level is high, the transmit-empty flag is set.
- R9: While the identification read strobe is held high, the identification byte does not change, whatever events occur. It resumes tracking one cycle after the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | EN_W (4) | Enable register write data |
| en_rdata | output | DATA_W (8) | Enable register readback |
| ls_set | input | 1 | Line-error event pulse (overrun, parity, framing or break) |
| rx_set | input | 1 | Character-loaded event pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| ms_set | input | 1 | Modem input change event pulse |
| lsr_rd | input | 1 | Line-status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| id_rd | input | 1 | Identification register read strobe, high for the whole access |
| irq | output | 1 | Interrupt request, active high |
| ident | output | DATA_W (8) | Identification byte |

## Verification
On every cycle, the assertions check the following:
- the interrupt line against the no-pending bit of the live identification value;
- that the priority grant is at most one-hot;
- that line-status and transmit-empty clear after their retiring accesses;
- that the identification read retires transmit-empty;
- that transmit-empty re-arms on an enable rising edge;
- that the byte stays stable during a read.

Only the bench's scenarios show the following:
- that the full mapping of every enable pattern against every pending pattern yields the right code;
- that ordered reads walk down the priority levels;
- that an identification read leaves the other causes alone;
- that set beats clear when both arrive in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int NSRC   = 4;
   localparam int CODE_W = 3;
   // source index equals priority rank, 0 is most urgent
   localparam int SRC_LS = 0;
   localparam int SRC_RX = 1;
   localparam int SRC_TX = 2;
   localparam int SRC_MS = 3;

   // cause code reported in identification bits 3:1
   function automatic logic [CODE_W-1:0] code_of(input int idx);
      return CODE_W'(NSRC - 1 - idx);
   endfunction

   // position of a source's bit inside the enable register
   function automatic int en_bit(input int idx);
      case (idx)
         SRC_LS:  return 2;
         SRC_RX:  return 0;
         SRC_TX:  return 1;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
   parameter int DATA_W = 8,
   parameter int EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [EN_W-1:0]   wdata,
   output logic [EN_W-1:0]   en_q,
   output logic [DATA_W-1:0] rdata
);
   if (EN_W > DATA_W) begin : g_bad_w
      $error("uirq_enable_reg: EN_W exceeds DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '0;
      else if (wr) en_q <= wdata;
   end

   assign rdata = DATA_W'(en_q);

   assert_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (en_q == $past(wdata)));
endmodule

// File: rtl/uirq_pend_cell.sv
module uirq_pend_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_q
);
   logic nxt;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (set_i)      nxt = 1'b1;
         else if (clr_i) nxt = 1'b0;
         else            nxt = pend_q;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr_i)      nxt = 1'b0;
         else if (set_i) nxt = 1'b1;
         else            nxt = pend_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= nxt;
   end

   // R5: a set event always leaves the flag pending when set has priority
   assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && SET_WINS) |=> pend_q);
endmodule

// File: rtl/uirq_tx_arm.sv
module uirq_tx_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_empty,
   input  logic en_tx,
   input  logic thr_wr,
   input  logic id_start,
   input  logic tx_reported,
   output logic set_o,
   output logic clr_o
);
   logic empty_d, en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_d <= 1'b1;
         en_d    <= 1'b0;
      end else begin
         empty_d <= thr_empty;
         en_d    <= en_tx;
      end
   end

   assign set_o = (thr_empty & ~empty_d) | (en_tx & ~en_d & thr_empty);
   assign clr_o = thr_wr | (id_start & tx_reported);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [N-1:0] grant;

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
            any      = 1'b1;
         end
      end
   end

   assert_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident import uirq_pkg::*; #(
   parameter int DATA_W   = 8,
   parameter int EN_W     = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic [EN_W-1:0]   en_wdata,
   output logic [DATA_W-1:0] en_rdata,
   input  logic              ls_set,
   input  logic              rx_set,
   input  logic              thr_empty,
   input  logic              ms_set,
   input  logic              lsr_rd,
   input  logic              rhr_rd,
   input  logic              msr_rd,
   input  logic              thr_wr,
   input  logic              id_rd,
   output logic              irq,
   output logic [DATA_W-1:0] ident
);
   localparam int IDX_W = $clog2(NSRC);

   if (DATA_W < CODE_W + 1) begin : g_bad_data
      $error("uirq_ident: DATA_W too small for the identification code");
   end
   if (EN_W != NSRC) begin : g_bad_en
      $error("uirq_ident: EN_W must equal the source count");
   end

   logic [EN_W-1:0]   en_q;
   logic [NSRC-1:0]   en_src, pend, set_v, clr_v, req;
   logic              any;
   logic [IDX_W-1:0]  win_idx;
   logic              id_rd_d, id_start, tx_reported;
   logic [DATA_W-1:0] ident_q, ident_live;

   uirq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
      .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
      .en_q(en_q), .rdata(en_rdata)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_map
      assign en_src[s] = en_q[en_bit(s)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_rd_d <= 1'b0;
      else        id_rd_d <= id_rd;
   end
   assign id_start    = id_rd & ~id_rd_d;
   assign tx_reported = ~ident_q[0] & (ident_q[CODE_W:1] == code_of(SRC_TX));

   uirq_tx_arm u_tx (
      .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .en_tx(en_src[SRC_TX]),
      .thr_wr(thr_wr), .id_start(id_start), .tx_reported(tx_reported),
      .set_o(set_v[SRC_TX]), .clr_o(clr_v[SRC_TX])
   );

   assign set_v[SRC_LS] = ls_set;
   assign clr_v[SRC_LS] = lsr_rd;
   assign set_v[SRC_RX] = rx_set;
   assign clr_v[SRC_RX] = rhr_rd;
   assign set_v[SRC_MS] = ms_set;
   assign clr_v[SRC_MS] = msr_rd;

   for (genvar s = 0; s < NSRC; s++) begin : g_pend
      uirq_pend_cell #(.SET_WINS(SET_WINS)) u_cell (
         .clk(clk), .rst_n(rst_n), .set_i(set_v[s]), .clr_i(clr_v[s]),
         .pend_q(pend[s])
      );
   end

   assign req = pend & en_src;

   uirq_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .req(req), .any(any), .idx(win_idx)
   );

   assign irq        = |req;
   assign ident_live = any ? DATA_W'({code_of(int'(win_idx)), 1'b0})
                           : DATA_W'(1);

   // freeze the returned byte for the whole read access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ident_q <= DATA_W'(1);
      else if (!id_rd) ident_q <= ident_live;
   end
   assign ident = ident_q;

   assert_irq_vs_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq != ident_live[0]);
   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && $past(id_rd)) |-> $stable(ident_q));
   assert_ls_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ls_set) |=> !pend[SRC_LS]);
   assert_thr_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !thr_empty) |=> !pend[SRC_TX]);
   assert_id_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (id_start && tx_reported && !set_v[SRC_TX]) |=> !pend[SRC_TX]);
   assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en_src[SRC_TX]) && thr_empty && $past(thr_empty)) |=> pend[SRC_TX]);
endmodule

// File: tb/uirq_ident_bench.sv
`timescale 1ns/1ps
module uirq_ident_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_wr = 0, ls_set = 0, rx_set = 0, thr_empty = 1, ms_set = 0;
   logic       lsr_rd = 0, rhr_rd = 0, msr_rd = 0, thr_wr = 0, id_rd = 0;
   logic [3:0] en_wdata = '0;
   logic [7:0] en_rdata, ident;
   logic       irq;
   int         errors = 0, checks = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   uirq_ident u_uirq_ident (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .en_rdata(en_rdata), .ls_set(ls_set), .rx_set(rx_set),
      .thr_empty(thr_empty), .ms_set(ms_set), .lsr_rd(lsr_rd),
      .rhr_rd(rhr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr), .id_rd(id_rd),
      .irq(irq), .ident(ident)
   );

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected byte: causes in priority order ls, rx, tx, ms
   function automatic logic [7:0] exp_id(input logic [3:0] e, input logic [3:0] p);
      if (p[0] && e[2]) return 8'h06;
      if (p[1] && e[0]) return 8'h04;
      if (p[2] && e[1]) return 8'h02;
      if (p[3] && e[3]) return 8'h00;
      return 8'h01;
   endfunction

   task automatic clear_all(input logic [3:0] e);
      lsr_rd = 1; rhr_rd = 1; msr_rd = 1; thr_wr = 1; thr_empty = 0;
      en_wr = 1; en_wdata = e;
      tick();
      lsr_rd = 0; rhr_rd = 0; msr_rd = 0; thr_wr = 0; en_wr = 0;
      tick();
   endtask

   task automatic raise(input logic [3:0] p);
      ls_set = p[0]; rx_set = p[1]; thr_empty = p[2]; ms_set = p[3];
      tick();
      ls_set = 0; rx_set = 0; ms_set = 0;
      tick(2);
   endtask

   task automatic id_read(input string tag, input logic [7:0] exp);
      id_rd = 1;
      tick();
      chk(tag, ident, exp);
      id_rd = 0;
      tick(2);
   endtask

   initial begin
      tick(3);
      chk("R1 reset enable", en_rdata, 8'h00);
      chk("R2 reset ident", ident, 8'h01);
      chk("R3 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1;
      tick();
      chk("R2 ident after reset", ident, 8'h01);

      // R1 upper bits read as zero
      en_wr = 1; en_wdata = 4'hF; tick(); en_wr = 0; tick();
      chk("R1 readback", en_rdata, 8'h0F);
      en_wr = 1; en_wdata = 4'h5; tick(); en_wr = 0; tick();
      chk("R1 readback 5", en_rdata, 8'h05);

      // R2 R3 R4 sweep all enable vs pending patterns
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 16; p++) begin
            clear_all(4'(e));
            raise(4'(p));
            chk($sformatf("R4 ident e=%0h p=%0h", e, p), ident, exp_id(4'(e), 4'(p)));
            chk($sformatf("R3 irq e=%0h p=%0h", e, p), {7'b0, irq},
                {7'b0, exp_id(4'(e), 4'(p)) != 8'h01});
         end
      end

      // R5 R7 walk down the priority levels
      clear_all(4'hF);
      raise(4'hF);
      chk("R4 all pending", ident, 8'h06);
      id_read("R7 read returns ls", 8'h06);
      chk("R7 ls kept after id read", ident, 8'h06);
      lsr_rd = 1; tick(); lsr_rd = 0; tick(2);
      chk("R5 ls cleared", ident, 8'h04);
      rhr_rd = 1; tick(); rhr_rd = 0; tick(2);
      chk("R5 rx cleared", ident, 8'h02);
      id_read("R7 read returns tx", 8'h02);
      chk("R7 tx cleared by id read", ident, 8'h00);
      msr_rd = 1; tick(); msr_rd = 0; tick(2);
      chk("R5 ms cleared", ident, 8'h01);
      chk("R3 irq low", {7'b0, irq}, 8'h00);

      // R5 set wins over clear in the same cycle
      rx_set = 1; rhr_rd = 1; tick(); rx_set = 0; rhr_rd = 0; tick(2);
      chk("R5 set wins", ident, 8'h04);

      // R9 byte frozen during access
      clear_all(4'hF);
      raise(4'h8);
      chk("R9 before", ident, 8'h00);
      id_rd = 1; tick();
      ls_set = 1; tick(); ls_set = 0; tick(2);
      chk("R9 frozen", ident, 8'h00);
      chk("R3 irq during read", {7'b0, irq}, 8'h01);
      id_rd = 0; tick(2);
      chk("R9 resumes", ident, 8'h06);

      // R6 R8 transmit-empty arming
      clear_all(4'h2);
      raise(4'h4);
      chk("R6 empty rise", ident, 8'h02);
      thr_wr = 1; tick(); thr_wr = 0; tick(2);
      chk("R6 write clears", ident, 8'h01);
      thr_empty = 0; tick(); thr_empty = 1; tick(3);
      chk("R6 rearm on rise", ident, 8'h02);
      id_read("R7 id read tx", 8'h02);
      tick(4);
      chk("R6 no rearm while high", ident, 8'h01);
      en_wr = 1; en_wdata = 4'h0; tick(); en_wr = 0; tick(2);
      en_wr = 1; en_wdata = 4'h2; tick(); en_wr = 0; tick(3);
      chk("R8 enable rise rearms", ident, 8'h02);
      chk("R8 irq", {7'b0, irq}, 8'h01);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule